// File: doc/BRIEF.md
# Receive Frame Store Writer

This block takes one incoming Ethernet frame at a time and lays it out in a page of packet RAM, in the layout that the rest of the controller and its driver expect. A frame opens with a one-cycle start strobe that carries the frame length. The block first decides whether the frame can be stored at all. If it can, it asks the page allocator for a page and writes a four-byte header. It then writes the frame bytes as they stream in, zero padding, an optional CRC-32 and a two-byte trailer. When the page is complete, the block pushes the page number onto the receive queue and pulses the receive interrupt set line.

Bytes arrive on a valid/ready stream. While the block is idle, `s_ready` is high and any byte offered without an accepted start is consumed and discarded. Once a frame is accepted, `s_ready` drops for the allocation and header cycles. It is high for exactly the frame's byte count during the data phase, taking one byte per cycle. It is low again while padding, CRC and trailer are written. The start strobe does not carry a data byte, and it is honoured only while the block is idle. The receive control bits (`rx_en`, `soft_rst`, `strip_crc`) are sampled at the start strobe. `can_accept` tells the upstream source whether a frame could currently be stored.

Top module: `rx_frame_writer`

## Requirements
- R1: A start strobe is dropped, with no allocation request, no RAM write and no queue push, when `rx_en` is low or `soft_rst` is high at the strobe.
- R2: The stored byte count is computed in four steps. Take the length rounded down to even, using 64 when the length is below 64. Add 6. Add a further 4 when `strip_crc` is low. A frame whose count exceeds 2048 is dropped without an allocation request.
- R3: When the allocator answers `alloc_ack` with `alloc_ok` low, the frame is dropped with no RAM write and no push, and the block returns to idle ready for the next frame. `alloc_req` stays high until `alloc_ack`.
- R4: `can_accept` is high when `rx_en` is low or `soft_rst` is high. Otherwise it is low when `pages_full` or `rxq_full` is high, and high when both are low.
- R5: Page bytes 0 and 1 hold the status word and bytes 2 and 3 hold the byte count, each least significant byte first.
- R6: Status bit 11 is set when the length exceeds 1518, and status bit 12 is set when the length is odd. All other status bits are zero.
- R7: Frame data starts at byte 4. A long frame stores its even part there. A frame shorter than 64 bytes stores every byte, including an odd last byte, then zeros up to frame offset 63, and from then on counts as 64 bytes long.
- R8: With `strip_crc` low, a CRC-32 is written as 4 bytes, least significant byte first, directly after the even-aligned data. It uses the reflected polynomial 0xEDB88320, starts at all ones, and is inverted at the end. It covers every frame byte, including an odd last byte and any padding.
- R9: The last two bytes of the page depend on the effective length. For an odd effective length they are the last frame byte, then 0x60. For an even effective length they are 0x00, then 0x40.
- R10: After the trailer, `q_push` and `irq_rcv_set` pulse together for exactly one cycle, with `q_page` equal to the granted page.
- R11: While the block is idle, `s_ready` is high and bytes offered without an accepted start write nothing. After reset the block is idle with all request, write and push outputs low.
- R12: Every RAM write of a frame targets the granted page at an address below 2048. A stored frame makes exactly byte-count writes, to addresses 0 through count-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable control bit |
| soft_rst | input | 1 | Soft reset control bit; blocks reception while high |
| strip_crc | input | 1 | When high, no CRC is stored |
| frm_start | input | 1 | One-cycle strobe opening a frame |
| frm_len | input | 12 | Frame length in bytes, valid with `frm_start` |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high with `s_valid` |
| s_data | input | 8 | Stream byte |
| can_accept | output | 1 | A frame could be stored now |
| pages_full | input | 1 | Allocator has no free page |
| rxq_full | input | 1 | Receive queue holds its maximum entries |
| alloc_req | output | 1 | Page allocation request |
| alloc_ack | input | 1 | Allocator answers the request |
| alloc_ok | input | 1 | Allocation succeeded (with `alloc_ack`) |
| alloc_page | input | 2 | Granted page number (with `alloc_ack`) |
| ram_we | output | 1 | Packet RAM byte write enable |
| ram_page | output | 2 | Page being written |
| ram_addr | output | 11 | Byte address within the page |
| ram_wdata | output | 8 | Byte written |
| q_push | output | 1 | Push the page onto the receive queue |
| q_page | output | 2 | Page number pushed |
| irq_rcv_set | output | 1 | Set the receive interrupt bit (bit 0) |

## Verification
A write pointer that drifts shows up during the frame itself, as a page image with bytes in the wrong places. It also shows up at push time, as a write count that differs from the header's byte count. A corrupted CRC register stays invisible until the last few write cycles of a frame that keeps its CRC, where it appears as four wrong bytes. A wrong held odd byte or a wrong effective-length decision shows only in the two trailer bytes. A sequencer stuck outside idle shows at once as `s_ready` staying low and no push ever arriving, so each frame is checked byte by byte against an independently computed image.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALLOC,
    ST_HDR,
    ST_DATA,
    ST_PAD,
    ST_CRC,
    ST_TRAIL,
    ST_DONE
  } rxw_state_e;

  localparam int          STAT_LONG_BIT = 11;
  localparam int          STAT_ODD_BIT  = 12;
  localparam logic [7:0]  TRAIL_ODD     = 8'h60;
  localparam logic [7:0]  TRAIL_EVEN    = 8'h40;
  localparam logic [31:0] CRC_POLY_REV  = 32'hEDB88320;

  // One byte of reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c_in,
                                             input logic [7:0]  d);
    logic [31:0] c;
    c = c_in ^ {24'h0, d};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REV) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxw_len_calc.sv
module rxw_len_calc #(
  parameter int LEN_W      = 12,
  parameter int CNT_W      = 13,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518
) (
  input  logic [LEN_W-1:0] len,
  input  logic             strip,
  output logic [CNT_W-1:0] count,
  output logic [15:0]      status,
  output logic             oversize,
  output logic             short_frame,
  output logic             odd_trail
);
  import rxw_pkg::*;

  logic [CNT_W-1:0] base;
  logic [LEN_W-1:0] len_even;

  assign len_even    = {len[LEN_W-1:1], 1'b0};
  assign short_frame = (len < LEN_W'(MIN_FRAME));
  assign base        = short_frame ? CNT_W'(MIN_FRAME) : CNT_W'(len_even);
  assign count       = base + CNT_W'(6) + (strip ? CNT_W'(0) : CNT_W'(4));
  assign oversize    = (count > CNT_W'(PAGE_BYTES));
  // A padded short frame behaves as 64 long, hence even.
  assign odd_trail   = !short_frame && len[0];

  always_comb begin
    status                = 16'h0000;
    status[STAT_LONG_BIT] = (len > LEN_W'(LONG_LIMIT));
    status[STAT_ODD_BIT]  = len[0];
  end

endmodule

// File: rtl/rxw_crc32.sv
module rxw_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);
  import rxw_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (clr)    crc_q <= '1;
    else if (en)     crc_q <= crc32_byte(crc_q, din);
  end

  assign crc_out = ~crc_q;

endmodule

// File: rtl/rxw_seq.sv
module rxw_seq #(
  parameter int LEN_W      = 12,
  parameter int CNT_W      = 13,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int PG_W       = 2,
  localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic              strip_crc,
  input  logic              frm_start,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  output logic              alloc_req,
  input  logic              alloc_ack,
  input  logic              alloc_ok,
  input  logic [PG_W-1:0]   alloc_page,
  output logic              ram_we,
  output logic [PG_W-1:0]   ram_page,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              q_push,
  output logic [PG_W-1:0]   q_page,
  output logic              irq_set,
  // length calculator interface
  output logic [LEN_W-1:0]  cur_len,
  output logic              cur_strip,
  input  logic [CNT_W-1:0]  count_in,
  input  logic [15:0]       status_in,
  input  logic              oversize,
  input  logic              short_frame,
  input  logic              odd_trail,
  // CRC interface
  output logic              crc_clr,
  output logic              crc_en,
  output logic [7:0]        crc_din,
  input  logic [31:0]       crc_val
);
  import rxw_pkg::*;

  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(3);
  localparam logic [CNT_W-1:0] PAD_LAST = CNT_W'(4 + MIN_FRAME - 1);

  rxw_state_e       state;
  logic [LEN_W-1:0] len_q;
  logic             strip_q;
  logic [PG_W-1:0]  page_q;
  logic [LEN_W-1:0] idx;
  logic [CNT_W-1:0] wptr;
  logic [1:0]       sub;
  logic [7:0]       held;
  logic             last_byte;
  logic             keep_byte;
  logic [15:0]      count16;

  assign cur_len   = (state == ST_IDLE) ? frm_len   : len_q;
  assign cur_strip = (state == ST_IDLE) ? strip_crc : strip_q;
  assign last_byte = (idx == len_q - LEN_W'(1));
  // The odd last byte of a long frame is held back for the trailer.
  assign keep_byte = !(last_byte && odd_trail);
  assign count16   = 16'(count_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      len_q   <= '0;
      strip_q <= 1'b0;
      page_q  <= '0;
      idx     <= '0;
      wptr    <= '0;
      sub     <= '0;
      held    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          idx  <= '0;
          wptr <= '0;
          sub  <= '0;
          if (frm_start && rx_en && !soft_rst && !oversize) begin
            len_q   <= frm_len;
            strip_q <= strip_crc;
            state   <= ST_ALLOC;
          end
        end
        ST_ALLOC: begin
          if (alloc_ack) begin
            if (alloc_ok) begin
              page_q <= alloc_page;
              state  <= ST_HDR;
            end else begin
              state  <= ST_IDLE;
            end
          end
        end
        ST_HDR: begin
          wptr <= wptr + CNT_W'(1);
          if (wptr == HDR_LAST)
            state <= (len_q == '0) ? ST_PAD : ST_DATA;
        end
        ST_DATA: begin
          if (s_valid) begin
            idx <= idx + LEN_W'(1);
            if (keep_byte) wptr <= wptr + CNT_W'(1);
            else           held <= s_data;
            if (last_byte) begin
              if (short_frame)  state <= ST_PAD;
              else if (strip_q) state <= ST_TRAIL;
              else              state <= ST_CRC;
            end
          end
        end
        ST_PAD: begin
          wptr <= wptr + CNT_W'(1);
          if (wptr == PAD_LAST)
            state <= strip_q ? ST_TRAIL : ST_CRC;
        end
        ST_CRC: begin
          wptr <= wptr + CNT_W'(1);
          sub  <= sub + 2'd1;
          if (sub == 2'd3) state <= ST_TRAIL;
        end
        ST_TRAIL: begin
          wptr <= wptr + CNT_W'(1);
          sub  <= sub + 2'd1;
          if (sub == 2'd1) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    s_ready   = 1'b0;
    alloc_req = 1'b0;
    ram_we    = 1'b0;
    ram_wdata = 8'h00;
    q_push    = 1'b0;
    irq_set   = 1'b0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    crc_din   = 8'h00;
    case (state)
      ST_IDLE: begin
        s_ready = 1'b1;
        crc_clr = 1'b1;
      end
      ST_ALLOC: alloc_req = 1'b1;
      ST_HDR: begin
        ram_we = 1'b1;
        case (wptr[1:0])
          2'd0:    ram_wdata = status_in[7:0];
          2'd1:    ram_wdata = status_in[15:8];
          2'd2:    ram_wdata = count16[7:0];
          default: ram_wdata = count16[15:8];
        endcase
      end
      ST_DATA: begin
        s_ready   = 1'b1;
        ram_we    = s_valid && keep_byte;
        ram_wdata = s_data;
        crc_en    = s_valid;
        crc_din   = s_data;
      end
      ST_PAD: begin
        ram_we = 1'b1;
        crc_en = 1'b1;
      end
      ST_CRC: begin
        ram_we    = 1'b1;
        ram_wdata = crc_val[8*sub +: 8];
      end
      ST_TRAIL: begin
        ram_we = 1'b1;
        if (sub[0]) ram_wdata = odd_trail ? TRAIL_ODD : TRAIL_EVEN;
        else        ram_wdata = odd_trail ? held : 8'h00;
      end
      ST_DONE: begin
        q_push  = 1'b1;
        irq_set = 1'b1;
      end
      default: ;
    endcase
  end

  assign ram_page = page_q;
  assign ram_addr = wptr[ADDR_W-1:0];
  assign q_page   = page_q;

  // R1: an allocation only follows an accepted start with reception enabled
  a_r1_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alloc_req) |-> $past(frm_start && rx_en && !soft_rst));

  // R3: the request is held until the allocator answers
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_ack) |=> alloc_req);

  // R10: completion is a single-cycle pulse
  a_r10_push_single: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |=> !q_push);

  // R12: writes stay inside the page
  a_r12_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wptr < CNT_W'(PAGE_BYTES)));

  // R12: the number of bytes written equals the stored byte count
  a_r12_push_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> (wptr == count_in));

endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer #(
  parameter int LEN_W      = 12,
  parameter int PAGE_BYTES = 2048,
  parameter int NUM_PAGES  = 4,
  parameter int MIN_FRAME  = 64,
  parameter int LONG_LIMIT = 1518,
  localparam int CNT_W     = $clog2(PAGE_BYTES) + 2,
  localparam int ADDR_W    = $clog2(PAGE_BYTES),
  localparam int PG_W      = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              soft_rst,
  input  logic              strip_crc,
  input  logic              frm_start,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  output logic              can_accept,
  input  logic              pages_full,
  input  logic              rxq_full,
  output logic              alloc_req,
  input  logic              alloc_ack,
  input  logic              alloc_ok,
  input  logic [PG_W-1:0]   alloc_page,
  output logic              ram_we,
  output logic [PG_W-1:0]   ram_page,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              q_push,
  output logic [PG_W-1:0]   q_page,
  output logic              irq_rcv_set
);

  logic [LEN_W-1:0] cur_len;
  logic             cur_strip;
  logic [CNT_W-1:0] count;
  logic [15:0]      status;
  logic             oversize, short_frame, odd_trail;
  logic             crc_clr, crc_en;
  logic [7:0]       crc_din;
  logic [31:0]      crc_val;

  assign can_accept = !rx_en || soft_rst || !(pages_full || rxq_full);

  rxw_len_calc #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES),
    .MIN_FRAME(MIN_FRAME), .LONG_LIMIT(LONG_LIMIT)
  ) calc_i (
    .len(cur_len), .strip(cur_strip), .count(count), .status(status),
    .oversize(oversize), .short_frame(short_frame), .odd_trail(odd_trail)
  );

  rxw_crc32 crc_i (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
    .din(crc_din), .crc_out(crc_val)
  );

  rxw_seq #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES),
    .MIN_FRAME(MIN_FRAME), .PG_W(PG_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst),
    .strip_crc(strip_crc), .frm_start(frm_start), .frm_len(frm_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .alloc_req(alloc_req), .alloc_ack(alloc_ack), .alloc_ok(alloc_ok),
    .alloc_page(alloc_page), .ram_we(ram_we), .ram_page(ram_page),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .q_push(q_push),
    .q_page(q_page), .irq_set(irq_rcv_set),
    .cur_len(cur_len), .cur_strip(cur_strip), .count_in(count),
    .status_in(status), .oversize(oversize), .short_frame(short_frame),
    .odd_trail(odd_trail), .crc_clr(crc_clr), .crc_en(crc_en),
    .crc_din(crc_din), .crc_val(crc_val)
  );

endmodule

// File: tb/rx_frame_writer_tb_top.sv
module rx_frame_writer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {length, strip, expected count, expected status}
  localparam logic [41:0] VEC [0:NV-1] = '{
    {12'd10,   1'b0, 13'd74,   16'h0000},
    {12'd11,   1'b0, 13'd74,   16'h1000},
    {12'd11,   1'b1, 13'd70,   16'h1000},
    {12'd64,   1'b0, 13'd74,   16'h0000},
    {12'd65,   1'b0, 13'd74,   16'h1000},
    {12'd63,   1'b0, 13'd74,   16'h1000},
    {12'd100,  1'b1, 13'd106,  16'h0000},
    {12'd1519, 1'b1, 13'd1524, 16'h1800},
    {12'd1518, 1'b0, 13'd1528, 16'h0000},
    {12'd2039, 1'b0, 13'd2048, 16'h1800},
    {12'd0,    1'b1, 13'd70,   16'h0000}
  };

  logic clk = 0, rst_n = 0;
  logic rx_en = 0, soft_rst = 0, strip_crc = 0, frm_start = 0;
  logic [11:0] frm_len = '0;
  logic s_valid = 0, s_ready;
  logic [7:0] s_data = '0;
  logic can_accept, pages_full = 0, rxq_full = 0;
  logic alloc_req, alloc_ack = 0, alloc_ok = 1;
  logic [1:0] alloc_page = '0;
  logic ram_we;
  logic [1:0] ram_page;
  logic [10:0] ram_addr;
  logic [7:0] ram_wdata;
  logic q_push, irq_rcv_set;
  logic [1:0] q_page;

  int checks = 0, errors = 0;
  int wr_cnt = 0, push_cnt = 0, irq_cnt = 0, req_cnt = 0, bad_page = 0;
  int last_q_page = 0, cur_page = 0;
  logic [7:0] cap  [0:2047];
  logic [7:0] expv [0:2047];
  int data_end, crc_end;

  rx_frame_writer dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .soft_rst(soft_rst),
    .strip_crc(strip_crc), .frm_start(frm_start), .frm_len(frm_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .can_accept(can_accept), .pages_full(pages_full), .rxq_full(rxq_full),
    .alloc_req(alloc_req), .alloc_ack(alloc_ack), .alloc_ok(alloc_ok),
    .alloc_page(alloc_page), .ram_we(ram_we), .ram_page(ram_page),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .q_push(q_push),
    .q_page(q_page), .irq_rcv_set(irq_rcv_set)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: samples a quarter period after the falling edge.
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst_n) begin
      if (ram_we) begin
        cap[ram_addr] = ram_wdata;
        wr_cnt++;
        if (int'(ram_page) != cur_page) bad_page++;
      end
      if (q_push) begin push_cnt++; last_q_page = int'(q_page); end
      if (irq_rcv_set) irq_cnt++;
      if (alloc_req) req_cnt++;
    end
  end

  // Allocator model: answers one cycle after a request.
  initial forever begin
    @(negedge clk);
    alloc_ack = alloc_req && !alloc_ack;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11: watchdog expired, actual hung expected idle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [7:0] pat(input int len, input int i);
    return 8'((i * 13 + len + 1) & 255);
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in;
    for (int k = 0; k < 8; k++) begin
      if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic build_exp(input int len, input bit strip, input int cnt, input int st);
    int eff, ev, p;
    logic [31:0] c;
    eff = (len < 64) ? 64 : len;
    ev  = eff & ~1;
    expv[0] = 8'(st); expv[1] = 8'(st >> 8);
    expv[2] = 8'(cnt); expv[3] = 8'(cnt >> 8);
    c = 32'hFFFFFFFF;
    for (int i = 0; i < eff; i++) c = crc_step(c, (i < len) ? pat(len, i) : 8'h00);
    c = ~c;
    for (int i = 0; i < ev; i++) expv[4+i] = (i < len) ? pat(len, i) : 8'h00;
    p = 4 + ev;
    data_end = p;
    if (!strip) begin
      for (int k = 0; k < 4; k++) expv[p+k] = c[8*k +: 8];
      p = p + 4;
    end
    crc_end = p;
    expv[p]   = eff[0] ? pat(len, len - 1) : 8'h00;
    expv[p+1] = eff[0] ? 8'h60 : 8'h40;
  endtask

  task automatic push_byte(input logic [7:0] b);
    bit r;
    s_valid = 1; s_data = b;
    forever begin
      r = s_ready;
      @(negedge clk);
      if (r) break;
    end
    s_valid = 0;
  endtask

  task automatic run_frame(input int len, input bit strip, input int page, input bit ok);
    int p0;
    strip_crc = strip; alloc_ok = ok; alloc_page = 2'(page); cur_page = page;
    for (int i = 0; i < 2048; i++) cap[i] = 'x;
    wr_cnt = 0; req_cnt = 0; bad_page = 0;
    p0 = push_cnt;
    @(negedge clk);
    frm_len = 12'(len); frm_start = 1;
    @(negedge clk);
    frm_start = 0;
    for (int i = 0; i < len; i++) push_byte(pat(len, i));
    for (int w = 0; w < 300 && push_cnt == p0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int len, cnt, st, p0, i0, mis_d, mis_c, mis_h;
    bit strip;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check(s_ready === 1'b1, "R11 reset ready", int'(s_ready), 1);
    check(alloc_req === 1'b0 && ram_we === 1'b0, "R11 reset quiet", int'(alloc_req | ram_we), 0);
    check(q_push === 1'b0 && irq_rcv_set === 1'b0, "R10 reset no push", int'(q_push), 0);
    @(negedge clk);
    rst_n = 1;
    rx_en = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      len = int'(VEC[v][41:30]); strip = VEC[v][29];
      cnt = int'(VEC[v][28:16]); st = int'(VEC[v][15:0]);
      build_exp(len, strip, cnt, st);
      p0 = push_cnt; i0 = irq_cnt;
      run_frame(len, strip, v % 4, 1);
      check(push_cnt - p0 == 1, $sformatf("R10 push len %0d", len), push_cnt - p0, 1);
      check(irq_cnt - i0 == 1, $sformatf("R10 irq len %0d", len), irq_cnt - i0, 1);
      check(last_q_page == v % 4, $sformatf("R10 page len %0d", len), last_q_page, v % 4);
      check(wr_cnt == cnt && bad_page == 0, $sformatf("R12 writes len %0d", len), wr_cnt, cnt);
      check({cap[3], cap[2]} === 16'(cnt), $sformatf("R2 R5 count len %0d", len),
            int'({cap[3], cap[2]}), cnt);
      check({cap[1], cap[0]} === 16'(st), $sformatf("R6 status len %0d", len),
            int'({cap[1], cap[0]}), st);
      mis_d = 0; mis_c = 0; mis_h = 0;
      for (int i = 4; i < cnt; i++) begin
        if (cap[i] !== expv[i]) begin
          if (i < data_end) mis_d++;
          else if (i < crc_end) mis_c++;
          else mis_h++;
        end
      end
      check(mis_d == 0, $sformatf("R7 data/pad len %0d", len), mis_d, 0);
      check(mis_c == 0, $sformatf("R8 crc len %0d", len), mis_c, 0);
      check(mis_h == 0, $sformatf("R9 trailer len %0d", len), mis_h, 0);
    end

    // R4 can_accept combinations
    rx_en = 0; pages_full = 1; #1;
    check(can_accept === 1'b1, "R4 disabled forces high", int'(can_accept), 1);
    rx_en = 1; #1;
    check(can_accept === 1'b0, "R4 pages full", int'(can_accept), 0);
    soft_rst = 1; #1;
    check(can_accept === 1'b1, "R4 soft reset forces high", int'(can_accept), 1);
    soft_rst = 0; pages_full = 0; rxq_full = 1; #1;
    check(can_accept === 1'b0, "R4 queue full", int'(can_accept), 0);
    rxq_full = 0; #1;
    check(can_accept === 1'b1, "R4 room", int'(can_accept), 1);

    // R1 drops
    rx_en = 0; p0 = push_cnt;
    run_frame(20, 0, 1, 1);
    check(req_cnt == 0 && wr_cnt == 0 && push_cnt == p0, "R1 rx disabled drop",
          req_cnt + wr_cnt + push_cnt - p0, 0);
    rx_en = 1; soft_rst = 1;
    run_frame(20, 0, 1, 1);
    check(req_cnt == 0 && wr_cnt == 0 && push_cnt == p0, "R1 soft reset drop",
          req_cnt + wr_cnt + push_cnt - p0, 0);
    soft_rst = 0;

    // R2 oversize drop: 2040 even + 10 = 2050
    run_frame(2040, 0, 2, 1);
    check(req_cnt == 0 && wr_cnt == 0 && push_cnt == p0, "R2 oversize drop",
          req_cnt + wr_cnt + push_cnt - p0, 0);

    // R3 allocation refused, then recovery
    run_frame(30, 1, 3, 0);
    check(req_cnt > 0, "R3 request made", req_cnt, 1);
    check(wr_cnt == 0 && push_cnt == p0, "R3 refused drop", wr_cnt + push_cnt - p0, 0);
    check(s_ready === 1'b1, "R3 back to idle", int'(s_ready), 1);
    run_frame(30, 1, 3, 1);
    check(push_cnt == p0 + 1 && last_q_page == 3, "R3 recovery push", push_cnt - p0, 1);

    // R11 stray bytes while idle
    wr_cnt = 0; p0 = push_cnt;
    for (int i = 0; i < 5; i++) push_byte(8'hA5);
    repeat (5) @(negedge clk);
    check(wr_cnt == 0 && push_cnt == p0, "R11 stray bytes ignored", wr_cnt, 0);
    check(s_ready === 1'b1, "R11 idle ready", int'(s_ready), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule